// File: doc/BRIEF.md
# Floating-Point to 32-Bit Integer Truncating Converter

This block turns an unpacked floating-point operand into a 32-bit two's-complement integer. The operand arrives as a class code, a sign, a signed unbiased exponent, a normalized mantissa whose top bit is the explicit leading one, and a sticky bit that stands for any nonzero bits already dropped below the mantissa. The mantissa is shifted right until its integer part sits in the low 32 bits. Every bit shifted out, together with the incoming sticky bit, decides the inexact flag.

The conversion always truncates toward zero, whatever rounding mode the surrounding unit uses. A result that does not fit, and any infinity or NaN operand, saturates to the largest integer of the operand's sign. In that case the operand-error flag is raised and the inexact flag is forced low. The datapath is combinational between an input strobe and a bank of output registers, so each result appears one clock after its strobe.

Top module: `f2i_trunc32`

## Requirements
- R1: While reset is high, and after it, until the first accepted operand, `out_vld`, `out_int`, `out_inexact` and `out_operr` are all zero.
- R2: `out_vld` is high exactly in the cycle after a cycle with `in_vld` high. Outputs are updated only from operands presented with `in_vld` high, and they hold their values otherwise.
- R3: The class code is 0 for zero, 1 for a finite number, 2 for infinity and 3 for NaN. A zero-class operand gives 0 with both flags low, whatever its sign.
- R4: Mantissa bit MANT_W-1 carries weight 2^exp. For a number with exponent 0 to 31 that does not overflow, the result is the integer part of the magnitude, negated in two's complement when the sign is set.
- R5: For a number that does not overflow, `out_inexact` is high exactly when a discarded mantissa bit or `in_sticky` is nonzero.
- R6: A number with a negative exponent gives 0 with `out_inexact` high and `out_operr` low. No underflow indication exists.
- R7: A number with an exponent of 32 or more overflows.
- R8: A positive truncated magnitude of 0x80000000 or more overflows. A negative one overflows only above 0x80000000, so -2^31 converts exactly.
- R9: Infinity and NaN operands overflow regardless of mantissa.
- R10: On overflow the result is 0x7FFFFFFF for a positive sign and 0x80000000 for a negative sign, with `out_operr` high and `out_inexact` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Operand strobe |
| in_cls | input | 2 | Class code: 0 zero, 1 number, 2 infinity, 3 NaN |
| in_sign | input | 1 | Operand sign, 1 for negative |
| in_exp | input | EXP_W | Signed unbiased exponent |
| in_mant | input | MANT_W | Mantissa with explicit leading one at the top bit |
| in_sticky | input | 1 | OR of bits already dropped below the mantissa |
| out_vld | output | 1 | Result strobe, one cycle after `in_vld` |
| out_int | output | 32 | Two's-complement integer result |
| out_inexact | output | 1 | Discarded bits were nonzero |
| out_operr | output | 1 | Overflow or non-finite operand; result saturated |

## Verification
On every cycle the assertions check the one-cycle strobe timing and the holding of the outputs between strobes. They also check that zero operands give a clean zero, that infinities and NaNs always flag an operand error, and that an operand error comes only with one of the two saturation values and never with inexact. Which integer a finite number maps to, where the sign-dependent overflow boundary lies, and which discarded bits set inexact can be seen only from the bench's directed operands. These include exponents 30, 31 and 32, the exact value -2^31, magnitudes one step past the limit, a negative exponent, and a set incoming sticky bit.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

    localparam int INT_W = 32;

    typedef enum logic [1:0] {
        CLS_ZERO = 2'd0,
        CLS_NUM  = 2'd1,
        CLS_INF  = 2'd2,
        CLS_NAN  = 2'd3
    } fcls_e;

    // Result of the alignment stage.
    typedef struct packed {
        logic             big;   // exponent at or beyond the integer width
        logic [INT_W-1:0] mag;   // truncated magnitude
        logic             lost;  // a discarded bit or sticky was nonzero
    } align_t;

    // Packed integer result with its flags.
    typedef struct packed {
        logic [INT_W-1:0] value;
        logic             inexact;
        logic             operr;
    } ires_t;

    // Saturation value for the given sign.
    function automatic logic [INT_W-1:0] sat_value(input logic neg);
        return neg ? {1'b1, {(INT_W-1){1'b0}}} : {1'b0, {(INT_W-1){1'b1}}};
    endfunction

endpackage

// File: rtl/f2i_align.sv
module f2i_align
    import f2i_pkg::*;
#(
    parameter int MANT_W = 40,
    parameter int EXP_W  = 16
) (
    input  logic signed [EXP_W-1:0]  exp_i,
    input  logic        [MANT_W-1:0] mant_i,
    input  logic                     sticky_i,
    output align_t                   al_o
);
    localparam int SH_W = $clog2(MANT_W + 1);
    localparam int EI_W = $clog2(INT_W);
    localparam logic signed [EXP_W-1:0] EXP_LIM = EXP_W'(INT_W);

    logic [SH_W-1:0]   sh;
    logic [MANT_W-1:0] shifted;
    logic [MANT_W-1:0] drop_mask;

    always_comb begin
        al_o      = '0;
        sh        = '0;
        shifted   = '0;
        drop_mask = '0;
        if (exp_i >= EXP_LIM) begin
            al_o.big = 1'b1;
        end else if (exp_i < 0) begin
            al_o.lost = (|mant_i) | sticky_i;
        end else begin
            sh        = SH_W'(MANT_W - 1) - SH_W'(exp_i[EI_W-1:0]);
            shifted   = mant_i >> sh;
            drop_mask = ~({MANT_W{1'b1}} << sh);
            al_o.mag  = shifted[INT_W-1:0];
            al_o.lost = (|(mant_i & drop_mask)) | sticky_i;
        end
    end

endmodule

// File: rtl/f2i_pack.sv
module f2i_pack
    import f2i_pkg::*;
(
    input  fcls_e  cls_i,
    input  logic   sign_i,
    input  align_t al_i,
    output ires_t  res_o
);
    logic [INT_W:0] limit;
    logic           too_big;
    logic           ovf;

    always_comb begin
        limit   = {2'b01, {(INT_W-1){1'b0}}} + (INT_W+1)'(sign_i);
        too_big = al_i.big || ({1'b0, al_i.mag} >= limit);
        ovf     = (cls_i == CLS_INF) || (cls_i == CLS_NAN)
               || ((cls_i == CLS_NUM) && too_big);
        res_o   = '0;
        if (ovf) begin
            res_o.value = sat_value(sign_i);
            res_o.operr = 1'b1;
        end else if (cls_i == CLS_NUM) begin
            res_o.value   = sign_i ? (~al_i.mag + 1'b1) : al_i.mag;
            res_o.inexact = al_i.lost;
        end
    end

endmodule

// File: rtl/f2i_trunc32.sv
module f2i_trunc32
    import f2i_pkg::*;
#(
    parameter int MANT_W = 40,
    parameter int EXP_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_vld,
    input  logic [1:0]               in_cls,
    input  logic                     in_sign,
    input  logic signed [EXP_W-1:0]  in_exp,
    input  logic [MANT_W-1:0]        in_mant,
    input  logic                     in_sticky,
    output logic                     out_vld,
    output logic [INT_W-1:0]         out_int,
    output logic                     out_inexact,
    output logic                     out_operr
);
    align_t al;
    ires_t  res;
    fcls_e  cls;

    assign cls = fcls_e'(in_cls);

    f2i_align #(.MANT_W(MANT_W), .EXP_W(EXP_W)) align_i (
        .exp_i    (in_exp),
        .mant_i   (in_mant),
        .sticky_i (in_sticky),
        .al_o     (al)
    );

    f2i_pack pack_i (
        .cls_i  (cls),
        .sign_i (in_sign),
        .al_i   (al),
        .res_o  (res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld     <= 1'b0;
            out_int     <= '0;
            out_inexact <= 1'b0;
            out_operr   <= 1'b0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) begin
                out_int     <= res.value;
                out_inexact <= res.inexact;
                out_operr   <= res.operr;
            end
        end
    end

    p_vld_follow_r2: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_vld);
    p_vld_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> !out_vld);
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> ($stable(out_int) && $stable(out_inexact) && $stable(out_operr)));
    p_zero_clean_r3: assert property (@(posedge clk) disable iff (rst)
        (in_vld && in_cls == 2'd0) |=> (out_int == '0 && !out_inexact && !out_operr));
    p_special_ovf_r9: assert property (@(posedge clk) disable iff (rst)
        (in_vld && in_cls[1]) |=> out_operr);
    p_big_exp_r7: assert property (@(posedge clk) disable iff (rst)
        (in_vld && in_cls == 2'd1 && in_exp >= 32) |=> out_operr);
    p_sat_excl_r10: assert property (@(posedge clk) disable iff (rst)
        out_operr |-> (!out_inexact &&
                       (out_int == 32'h7FFF_FFFF || out_int == 32'h8000_0000)));

endmodule

// File: tb/f2i_trunc32_tb_top.sv
module f2i_trunc32_tb_top;
    localparam int MANT_W = 40;
    localparam int EXP_W  = 16;

    logic                    clk = 1'b0;
    logic                    rst;
    logic                    in_vld;
    logic [1:0]              in_cls;
    logic                    in_sign;
    logic signed [EXP_W-1:0] in_exp;
    logic [MANT_W-1:0]       in_mant;
    logic                    in_sticky;
    logic                    out_vld;
    logic [31:0]             out_int;
    logic                    out_inexact;
    logic                    out_operr;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    f2i_trunc32 #(.MANT_W(MANT_W), .EXP_W(EXP_W)) dut_i (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_cls(in_cls),
        .in_sign(in_sign), .in_exp(in_exp), .in_mant(in_mant),
        .in_sticky(in_sticky), .out_vld(out_vld), .out_int(out_int),
        .out_inexact(out_inexact), .out_operr(out_operr)
    );

    localparam logic [MANT_W-1:0] ONE = {1'b1, {(MANT_W-1){1'b0}}};

    task automatic check(input string req, input logic [31:0] ei,
                         input logic ex, input logic eo, input logic ev);
        n_chk++;
        if (out_int !== ei || out_inexact !== ex || out_operr !== eo || out_vld !== ev) begin
            n_fail++;
            $display("FAIL %s: got int=%h ix=%b oe=%b vld=%b, expected int=%h ix=%b oe=%b vld=%b",
                     req, out_int, out_inexact, out_operr, out_vld, ei, ex, eo, ev);
        end
    endtask

    task automatic apply(input string req, input logic [1:0] c, input logic s,
                         input int e, input logic [MANT_W-1:0] m, input logic st,
                         input logic [31:0] ei, input logic ex, input logic eo);
        @(negedge clk);
        in_vld = 1'b1; in_cls = c; in_sign = s; in_exp = EXP_W'(e);
        in_mant = m; in_sticky = st;
        @(negedge clk);
        in_vld = 1'b0;
        check(req, ei, ex, eo, 1'b1);
    endtask

    task automatic t_reset;
        rst = 1'b1; in_vld = 1'b0; in_cls = 2'd0; in_sign = 1'b0;
        in_exp = '0; in_mant = '0; in_sticky = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 during reset", 32'h0, 1'b0, 1'b0, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", 32'h0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_zero;
        apply("R3 zero positive", 2'd0, 1'b0, 5, ONE, 1'b1, 32'h0, 1'b0, 1'b0);
        apply("R3 zero negative", 2'd0, 1'b1, 40, ONE, 1'b0, 32'h0, 1'b0, 1'b0);
    endtask

    task automatic t_exact;
        apply("R4 one", 2'd1, 1'b0, 0, ONE, 1'b0, 32'd1, 1'b0, 1'b0);
        apply("R4 thirty-two", 2'd1, 1'b0, 5, ONE, 1'b0, 32'd32, 1'b0, 1'b0);
        apply("R4 minus one", 2'd1, 1'b1, 0, ONE, 1'b0, 32'hFFFF_FFFF, 1'b0, 1'b0);
    endtask

    task automatic t_fraction;
        apply("R5 3.5 truncates", 2'd1, 1'b0, 1, 40'hE0_0000_0000, 1'b0, 32'd3, 1'b1, 1'b0);
        apply("R5 -3.5 truncates", 2'd1, 1'b1, 1, 40'hE0_0000_0000, 1'b0, 32'hFFFF_FFFD, 1'b1, 1'b0);
        apply("R5 sticky only", 2'd1, 1'b0, 0, ONE, 1'b1, 32'd1, 1'b1, 1'b0);
        apply("R5 max positive inexact", 2'd1, 1'b0, 30, 40'hFF_FFFF_FFFF, 1'b0, 32'h7FFF_FFFF, 1'b1, 1'b0);
    endtask

    task automatic t_negexp;
        apply("R6 half negative", 2'd1, 1'b1, -1, ONE, 1'b0, 32'h0, 1'b1, 1'b0);
        apply("R6 tiny positive", 2'd1, 1'b0, -200, ONE, 1'b0, 32'h0, 1'b1, 1'b0);
    endtask

    task automatic t_bounds;
        apply("R7 exponent 32", 2'd1, 1'b0, 32, ONE, 1'b0, 32'h7FFF_FFFF, 1'b0, 1'b1);
        apply("R7 exponent 32 negative", 2'd1, 1'b1, 32, ONE, 1'b1, 32'h8000_0000, 1'b0, 1'b1);
        apply("R8 +2^31 overflows", 2'd1, 1'b0, 31, ONE, 1'b0, 32'h7FFF_FFFF, 1'b0, 1'b1);
        apply("R8 -2^31 exact", 2'd1, 1'b1, 31, ONE, 1'b0, 32'h8000_0000, 1'b0, 1'b0);
        apply("R8 -2^31 with fraction", 2'd1, 1'b1, 31, 40'h80_0000_0001, 1'b0, 32'h8000_0000, 1'b1, 1'b0);
        apply("R10 -(2^31+1) saturates", 2'd1, 1'b1, 31, 40'h80_0000_0100, 1'b0, 32'h8000_0000, 1'b0, 1'b1);
        apply("R10 inexact overflow clears ix", 2'd1, 1'b0, 31, 40'hFF_FFFF_FFFF, 1'b1, 32'h7FFF_FFFF, 1'b0, 1'b1);
    endtask

    task automatic t_special;
        apply("R9 +inf", 2'd2, 1'b0, 0, ONE, 1'b0, 32'h7FFF_FFFF, 1'b0, 1'b1);
        apply("R9 -inf", 2'd2, 1'b1, 0, ONE, 1'b0, 32'h8000_0000, 1'b0, 1'b1);
        apply("R9 NaN small exponent", 2'd3, 1'b0, -3, 40'hC0_0000_0001, 1'b1, 32'h7FFF_FFFF, 1'b0, 1'b1);
    endtask

    task automatic t_hold;
        apply("R2 load", 2'd1, 1'b0, 2, ONE, 1'b0, 32'd4, 1'b0, 1'b0);
        @(negedge clk);
        in_cls = 2'd2; in_sign = 1'b1; in_exp = 16'sd7; in_sticky = 1'b1;
        @(negedge clk);
        check("R2 hold without strobe", 32'd4, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        check("R2 still holding", 32'd4, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        t_reset();
        t_zero();
        t_exact();
        t_fraction();
        t_negexp();
        t_bounds();
        t_special();
        t_hold();
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule